// File: doc/BRIEF.md
# Three-Phase Gate Command Conditioner with Dead Time

This block sits between a motor-control sequencer and the gate drivers of a three-phase inverter bridge. Each phase has a high-side and a low-side command, and there is one more command for an auxiliary low-side switch, such as a brake chopper or a boost stage. The block drives seven gate-enable outputs. Every command first goes through a glitch filter. A level change reaches the rest of the logic only after it has held for `FILT_LEN` consecutive clock cycles, so narrow spikes on the command lines never reach a gate.

Inside each phase, an interlock makes sure the two switches are never enabled together. It also enforces a gap of exactly `DEAD_LEN` clock cycles between one side turning off and the other side turning on. If both commands of a phase are requested at once, both gates of that phase stay off. The gap count starts only when one of the two requests is withdrawn. The auxiliary channel is filtered but has no partner switch, so it gets no gap. A single shutdown input overrides everything: on the next clock edge it turns off all seven gates.

All inputs are taken as synchronous to `clk`. All timing is counted in cycles of that clock. The default lengths (35 and 29 cycles) assume a 100 MHz clock.

Top module: `bridge_gate_conditioner`

## Requirements
- R1: During reset and right after it, all seven gate outputs are low.
- R2: A command pulse that lasts fewer than `FILT_LEN` cycles never changes any gate output.
- R3: A command pulse that lasts `FILT_LEN` cycles or more reaches its output with the same width in cycles.
- R4: Gate-command channel numbering is: 0–2 = high side of phases 0–2, 3–5 = low side of phases 0–2, 6 = auxiliary. On every one of these seven channels, the output responds to a command change after exactly `FILT_LEN`+1 rising edges, counting the first edge that samples the new level. This holds for both turn-on and turn-off, provided the opposite side of that phase has been off for at least `DEAD_LEN` cycles.
- R5: When a phase switches from one side to the other, the incoming side turns on exactly `DEAD_LEN` cycles after the outgoing side turns off.
- R6: The high and low gates of one phase are never high in the same cycle.
- R7: While both commands of a phase are asserted, both gates of that phase are low. A gate that was on turns off with the R4 latency. Once one command is released, the remaining side turns on `FILT_LEN`+`DEAD_LEN`+1 edges after the first edge that samples the release.
- R8: On the first clock edge that samples `shutdown` high, all seven gates go low. They stay low for as long as `shutdown` stays high, whatever the commands do.
- R9: After shutdown is released, a phase gate turns on exactly `DEAD_LEN` edges after the last edge that sampled `shutdown` high, if its filtered command is steady and alone in its phase.
- R10: The auxiliary gate has no dead time. It turns on one edge after shutdown is released, and its latency does not depend on activity in the phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdHigh | input | NUM_PH | High-side on request, one bit per phase |
| cmdLow | input | NUM_PH | Low-side on request, one bit per phase |
| cmdAux | input | 1 | Auxiliary low-side on request |
| shutdown | input | 1 | Global kill; forces all gates low |
| gateHigh | output | NUM_PH | High-side gate enable, one bit per phase |
| gateLow | output | NUM_PH | Low-side gate enable, one bit per phase |
| gateAux | output | 1 | Auxiliary gate enable |

## Verification
A filter counter stuck in a wrong state shows up on the first sweep as a pulse that leaks through or a width that is one cycle off, because every accepted pulse is compared cycle by cycle against its input. A gap counter that saturates early, or restarts from the wrong value, moves the incoming edge of a side swap. It does the same to the first edge after an overlap or a shutdown release. Each of those edges is compared with an exact cycle number within a few tens of cycles of the stimulus. An interlock fault shows within one cycle as both gates of a phase high, and a per-cycle monitor flags it.

// File: rtl/dtPkg.sv
package dtPkg;

  // Per-phase request from the interlock control to the gate registers.
  typedef struct packed {
    logic hiSet;
    logic hiClr;
    logic loSet;
    logic loClr;
  } gateStrobe_t;

endpackage

// File: rtl/dtPulseFilter.sv
module dtPulseFilter #(
  parameter int FILT_LEN = 35
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [CW-1:0] runCnt;
  logic          heldLevel;

  // A differing level must be seen on FILT_LEN consecutive edges before it is adopted.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldLevel <= 1'b0;
      runCnt    <= '0;
    end else if (rawIn == heldLevel) begin
      runCnt <= '0;
    end else if (runCnt == CW'(FILT_LEN - 1)) begin
      heldLevel <= rawIn;
      runCnt    <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign cleanOut = heldLevel;

  // R2: an input that agrees with the held level cannot move the output.
  a_r2_hold_when_equal: assert property (@(posedge clk) disable iff (!rstN)
    (rawIn == cleanOut) |=> $stable(cleanOut));

endmodule

// File: rtl/dtGateDatapath.sv
module dtGateDatapath
  import dtPkg::*;
#(
  parameter int NUM_PH   = 3,
  parameter int FILT_LEN = 35
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_PH-1:0]        cmdHigh,
  input  logic [NUM_PH-1:0]        cmdLow,
  input  logic                     cmdAux,
  input  logic                     shutdown,
  input  gateStrobe_t [NUM_PH-1:0] strobes,
  output logic [NUM_PH-1:0]        filtHigh,
  output logic [NUM_PH-1:0]        filtLow,
  output logic [NUM_PH-1:0]        gateHigh,
  output logic [NUM_PH-1:0]        gateLow,
  output logic                     gateAux
);
  localparam int NCH = 2 * NUM_PH + 1;

  logic [NCH-1:0] rawBus;
  logic [NCH-1:0] cleanBus;
  logic           auxFilt;
  logic           auxQ;

  assign rawBus = {cmdAux, cmdLow, cmdHigh};

  for (genvar c = 0; c < NCH; c++) begin : gFilt
    dtPulseFilter #(.FILT_LEN(FILT_LEN)) uFilt (
      .clk      (clk),
      .rstN     (rstN),
      .rawIn    (rawBus[c]),
      .cleanOut (cleanBus[c])
    );
  end

  assign filtHigh = cleanBus[NUM_PH-1:0];
  assign filtLow  = cleanBus[2*NUM_PH-1:NUM_PH];
  assign auxFilt  = cleanBus[NCH-1];

  for (genvar g = 0; g < NUM_PH; g++) begin : gGate
    logic hiQ;
    logic loQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hiQ <= 1'b0;
        loQ <= 1'b0;
      end else if (shutdown) begin
        hiQ <= 1'b0;
        loQ <= 1'b0;
      end else begin
        if (strobes[g].hiSet)      hiQ <= 1'b1;
        else if (strobes[g].hiClr) hiQ <= 1'b0;
        if (strobes[g].loSet)      loQ <= 1'b1;
        else if (strobes[g].loClr) loQ <= 1'b0;
      end
    end

    assign gateHigh[g] = hiQ;
    assign gateLow[g]  = loQ;

    // R6: the two switches of a phase are never enabled together.
    a_r6_no_shoot_through: assert property (@(posedge clk) disable iff (!rstN)
      !(hiQ && loQ));
  end

  // Auxiliary channel: filtered command, kill override, no gap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         auxQ <= 1'b0;
    else if (shutdown) auxQ <= 1'b0;
    else               auxQ <= auxFilt;
  end

  assign gateAux = auxQ;

  // R8: a sampled shutdown leaves every gate low after that edge.
  a_r8_kill_clears: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |=> (gateHigh == '0 && gateLow == '0 && !gateAux));

  // R10: the auxiliary gate follows its filtered command one edge later.
  a_r10_aux_follows: assert property (@(posedge clk) disable iff (!rstN)
    (!shutdown && auxFilt) |=> gateAux);

endmodule

// File: rtl/dtGapControl.sv
module dtGapControl
  import dtPkg::*;
#(
  parameter int NUM_PH   = 3,
  parameter int DEAD_LEN = 29
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     shutdown,
  input  logic [NUM_PH-1:0]        filtHigh,
  input  logic [NUM_PH-1:0]        filtLow,
  input  logic [NUM_PH-1:0]        gateHigh,
  input  logic [NUM_PH-1:0]        gateLow,
  output gateStrobe_t [NUM_PH-1:0] strobes
);
  localparam int GW = $clog2(DEAD_LEN + 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(DEAD_LEN);
  localparam logic [GW-1:0] GAP_ONE  = GW'(1);

  for (genvar g = 0; g < NUM_PH; g++) begin : gPhase
    logic        hiOnly;
    logic        loOnly;
    logic        bothCmd;
    logic        gapDone;
    logic        anyOn;
    logic [GW-1:0] gapCnt;
    gateStrobe_t stb;

    assign hiOnly  = filtHigh[g] && !filtLow[g];
    assign loOnly  = filtLow[g]  && !filtHigh[g];
    assign bothCmd = filtHigh[g] && filtLow[g];
    assign anyOn   = gateHigh[g] || gateLow[g];
    assign gapDone = (gapCnt == GAP_FULL);

    always_comb begin
      stb.hiClr = gateHigh[g] && !hiOnly;
      stb.loClr = gateLow[g]  && !loOnly;
      stb.hiSet = hiOnly && !anyOn && gapDone;
      stb.loSet = loOnly && !anyOn && gapDone;
    end

    assign strobes[g] = stb;

    // Gap counter: value 1 in the cycle after a turn-off, saturating at DEAD_LEN.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gapCnt <= GAP_FULL;
      end else if (shutdown || stb.hiClr || stb.loClr) begin
        gapCnt <= GAP_ONE;
      end else if (bothCmd || anyOn) begin
        gapCnt <= '0;
      end else if (!gapDone) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end

    // R5: the gap count never runs past its target.
    a_r5_gap_bounded: assert property (@(posedge clk) disable iff (!rstN)
      gapCnt <= GAP_FULL);

    // R7: two simultaneous requests leave both gates of the phase off.
    a_r7_overlap_off: assert property (@(posedge clk) disable iff (!rstN)
      bothCmd |=> (!gateHigh[g] && !gateLow[g]));
  end

endmodule

// File: rtl/bridge_gate_conditioner.sv
module bridge_gate_conditioner
  import dtPkg::*;
#(
  parameter int NUM_PH   = 3,
  parameter int FILT_LEN = 35,
  parameter int DEAD_LEN = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_PH-1:0] cmdHigh,
  input  logic [NUM_PH-1:0] cmdLow,
  input  logic              cmdAux,
  input  logic              shutdown,
  output logic [NUM_PH-1:0] gateHigh,
  output logic [NUM_PH-1:0] gateLow,
  output logic              gateAux
);
  gateStrobe_t [NUM_PH-1:0] strobes;
  logic [NUM_PH-1:0]        filtHigh;
  logic [NUM_PH-1:0]        filtLow;

  dtGateDatapath #(.NUM_PH(NUM_PH), .FILT_LEN(FILT_LEN)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .cmdHigh  (cmdHigh),
    .cmdLow   (cmdLow),
    .cmdAux   (cmdAux),
    .shutdown (shutdown),
    .strobes  (strobes),
    .filtHigh (filtHigh),
    .filtLow  (filtLow),
    .gateHigh (gateHigh),
    .gateLow  (gateLow),
    .gateAux  (gateAux)
  );

  dtGapControl #(.NUM_PH(NUM_PH), .DEAD_LEN(DEAD_LEN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .shutdown (shutdown),
    .filtHigh (filtHigh),
    .filtLow  (filtLow),
    .gateHigh (gateHigh),
    .gateLow  (gateLow),
    .strobes  (strobes)
  );

endmodule

// File: tb/tb_bridge_gate_conditioner.sv
module tb_bridge_gate_conditioner;
  localparam int NP   = 3;
  localparam int FL   = 5;
  localparam int DL   = 4;
  localparam int QUIET = FL + DL + 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] cmdHigh = '0;
  logic [NP-1:0] cmdLow = '0;
  logic          cmdAux = 1'b0;
  logic          shutdown = 1'b0;
  logic [NP-1:0] gateHigh;
  logic [NP-1:0] gateLow;
  logic          gateAux;

  int checks = 0;
  int errors = 0;
  int shootViol = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bridge_gate_conditioner #(.NUM_PH(NP), .FILT_LEN(FL), .DEAD_LEN(DL)) dut (
    .clk(clk), .rstN(rstN), .cmdHigh(cmdHigh), .cmdLow(cmdLow), .cmdAux(cmdAux),
    .shutdown(shutdown), .gateHigh(gateHigh), .gateLow(gateLow), .gateAux(gateAux)
  );

  // R6 monitor: both gates of one phase high in any cycle.
  always @(negedge clk) if (rstN && ((gateHigh & gateLow) != '0)) shootViol++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Channel map: 0..2 high side, 3..5 low side, 6 auxiliary.
  task automatic setCmd(input int ch, input logic v);
    if (ch < NP) cmdHigh[ch] = v;
    else if (ch < 2*NP) cmdLow[ch-NP] = v;
    else cmdAux = v;
  endtask

  function automatic logic getOut(input int ch);
    if (ch < NP) return gateHigh[ch];
    else if (ch < 2*NP) return gateLow[ch-NP];
    else return gateAux;
  endfunction

  task automatic quiet();
    cmdHigh = '0; cmdLow = '0; cmdAux = 1'b0; shutdown = 1'b0;
    repeat (QUIET) step();
  endtask

  task automatic pulseTest(input int ch, input int w);
    int first = -1;
    int highCnt = 0;
    quiet();
    setCmd(ch, 1'b1);
    for (int n = 1; n <= w + FL + 6; n++) begin
      step();
      if (getOut(ch)) begin
        highCnt++;
        if (first < 0) first = n;
      end
      if (n == w) setCmd(ch, 1'b0);
    end
    if (w < FL) check(highCnt == 0, "R2 short pulse blocked", highCnt, 0);
    else begin
      check(highCnt == w, "R3 width preserved", highCnt, w);
      check(first == FL + 1, "R4 latency", first, FL + 1);
    end
  endtask

  task automatic deadTest(input int p, input bit hiFirst);
    int offCh = hiFirst ? p : p + NP;
    int onCh  = hiFirst ? p + NP : p;
    int fallN = -1, riseN = -1, auxN = -1;
    quiet();
    setCmd(offCh, 1'b1);
    repeat (FL + 3) step();
    check(getOut(offCh) == 1'b1, "R4 first side on", getOut(offCh), 1);
    setCmd(offCh, 1'b0);
    setCmd(onCh, 1'b1);
    if (p == 0) cmdAux = 1'b1;
    for (int n = 1; n <= FL + DL + 6; n++) begin
      step();
      if (fallN < 0 && !getOut(offCh)) fallN = n;
      if (riseN < 0 && getOut(onCh)) riseN = n;
      if (auxN < 0 && gateAux) auxN = n;
    end
    check(fallN == FL + 1, "R4 turn-off latency", fallN, FL + 1);
    check(riseN - fallN == DL, "R5 dead time", riseN - fallN, DL);
    if (p == 0) check(auxN == FL + 1, "R10 aux unaffected", auxN, FL + 1);
  endtask

  task automatic overlapTest(input int p);
    int offN = -1, riseN = -1;
    bit loSeen = 0;
    quiet();
    cmdHigh[p] = 1'b1;
    repeat (FL + 3) step();
    cmdLow[p] = 1'b1;
    for (int n = 1; n <= FL + DL + 6; n++) begin
      step();
      if (offN < 0 && !gateHigh[p]) offN = n;
      if (gateLow[p]) loSeen = 1;
    end
    check(offN == FL + 1, "R7 overlap turns high off", offN, FL + 1);
    check(!loSeen, "R7 low held off during overlap", loSeen, 0);
    cmdHigh[p] = 1'b0;
    for (int n = 1; n <= FL + DL + 6; n++) begin
      step();
      if (riseN < 0 && gateLow[p]) riseN = n;
    end
    check(riseN == FL + DL + 1, "R7 turn-on after release", riseN, FL + DL + 1);
  endtask

  task automatic killTest();
    int zeroViol = 0;
    int lo0N = -1, lo1N = -1, auxN = -1;
    quiet();
    cmdHigh[0] = 1'b1; cmdLow[1] = 1'b1; cmdAux = 1'b1;
    repeat (FL + DL + 3) step();
    check(gateHigh[0] && gateLow[1] && gateAux, "R8 setup gates on",
          {gateHigh[0], gateLow[1], gateAux}, 7);
    shutdown = 1'b1;
    step();
    check(gateHigh == '0 && gateLow == '0 && !gateAux, "R8 kill next edge",
          {gateAux, gateLow, gateHigh}, 0);
    cmdHigh[0] = 1'b0; cmdLow[0] = 1'b1;
    repeat (2*FL + DL) begin
      step();
      if (gateHigh != '0 || gateLow != '0 || gateAux) zeroViol++;
    end
    check(zeroViol == 0, "R8 held low during kill", zeroViol, 0);
    shutdown = 1'b0;
    for (int n = 1; n <= DL + 3; n++) begin
      step();
      if (lo0N < 0 && gateLow[0]) lo0N = n;
      if (lo1N < 0 && gateLow[1]) lo1N = n;
      if (auxN < 0 && gateAux) auxN = n;
    end
    check(lo0N == DL, "R9 new side after kill", lo0N, DL);
    check(lo1N == DL, "R9 steady side after kill", lo1N, DL);
    check(auxN == 1, "R10 aux after kill", auxN, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(gateHigh == '0 && gateLow == '0 && !gateAux, "R1 in reset",
          {gateAux, gateLow, gateHigh}, 0);
    rstN = 1'b1;
    repeat (2) step();
    check(gateHigh == '0 && gateLow == '0 && !gateAux, "R1 after reset",
          {gateAux, gateLow, gateHigh}, 0);
    for (int ch = 0; ch < 2*NP + 1; ch++)
      for (int w = 1; w <= FL + 3; w++) pulseTest(ch, w);
    for (int p = 0; p < NP; p++) begin
      deadTest(p, 1'b1);
      deadTest(p, 1'b0);
      overlapTest(p);
    end
    killTest();
    quiet();
    check(shootViol == 0, "R6 no shoot-through", shootViol, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule